// File: doc/BRIEF.md
# Banked ROM/RAM Cartridge Mapper

This block sits between an 8-bit CPU bus and a cartridge's ROM and RAM. CPU writes into the ROM half of the address space never reach the ROM. Instead they load four small control registers:

- a RAM unlock flag;
- a 5-bit primary ROM bank;
- a 2-bit secondary bank;
- a banking mode bit.

From these registers the mapper turns every CPU address below 0x8000 into a physical ROM byte address. It also holds the cartridge RAM internally and serves it through the 0xA000–0xBFFF window.

The secondary register does one of two jobs. On the two largest ROM sizes it supplies the upper ROM bank bits. With the largest RAM option it picks the RAM bank. The mode bit decides two things:

- whether the secondary value also remaps the fixed 0x0000–0x3FFF window;
- whether it selects the RAM bank.

The ROM and RAM sizes come in on static select inputs. RAM bank size is a parameter: `RAM_AW` bits of window offset, default 512 bytes per bank. The options are:

- the largest RAM option is four such banks;
- the middle option is one bank;
- the smallest option is a quarter bank.

Window offset bits above the bank size are ignored, so smaller RAM wraps. All outputs are combinational from the address and the register state. Register writes are single-cycle strobes that take effect at the next clock edge. There is no back-pressure: the mapper accepts a write on every cycle.

Top module: `bank_mapper`

## Requirements
- R1: After reset the primary bank reads as 1, the secondary bank and mode are 0, and RAM is locked, so address 0x4000 maps to ROM byte 0x4000 and RAM window reads return 0xFF.
- R2: A write with address[15:13]=000 unlocks RAM when data[3:0]=0xA and locks it for any other value.
- R3: A write with address[15:13]=001 loads the primary bank. If data[4:0]=0 the bank becomes 1. Otherwise it is data masked by 1, 3, 7, 15 or 31 for ROM size select 0, 1, 2, 3 and ≥4 (32 KB·2^sel), so masking can leave bank 0.
- R4: A write with address[15:13]=010 stores data[1:0] as the secondary bank. A write with address[15:13]=011 stores data[0] as the mode bit.
- R5: For addresses 0x4000–0x7FFF, rom_addr = bank·0x4000 + addr[13:0]. With ROM size select 5 (1 MB), bank bit 5 is secondary[0]. With select 6 (2 MB), bank bits 6:5 are the secondary value. Below select 5 those bits are 0.
- R6: For addresses 0x0000–0x3FFF the bank is 0 in mode 0. In mode 1 it is secondary<<5, keeping only the bits valid for the ROM size (secondary[0] at 1 MB, both bits at 2 MB, none below).
- R7: With RAM size select 2 (four banks), mode 1 places RAM accesses in bank = secondary, and mode 0 always uses bank 0.
- R8: With RAM size select 1 (one bank) or 0 (quarter bank), offsets wrap modulo that size and the secondary value is ignored.
- R9: While RAM is locked, window reads return 0xFF and window writes leave the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_size_sel | input | 3 | ROM size, 32 KB·2^sel, 0..6 |
| ram_size_sel | input | 2 | 0 quarter bank, 1 one bank, 2 four banks |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | One-cycle write strobe |
| rom_addr | output | 21 | Physical ROM byte address for cpu_addr < 0x8000 |
| ram_rdata | output | 8 | RAM window read data, 0xFF when locked or outside the window |

## Verification
The hardest state to reach is a RAM bank other than 0 holding data distinct from bank 0 at the same window offset. Reaching it needs the largest RAM size, mode 1, an unlock and a secondary write, all in the right order. The bench writes different bytes at one offset under several secondary values. It then reads them back after flipping mode and secondary, so any aliasing of banks shows up. Blocked writes are proven by unlocking again afterwards and finding the old byte intact.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int LOW_W  = 5;
  localparam int SEC_W  = 2;
  localparam int WIN_W  = 14;
  localparam int BANK_W = LOW_W + SEC_W;
  localparam int ROM_AW = BANK_W + WIN_W;

  typedef enum logic [1:0] {
    REG_UNLOCK = 2'd0,
    REG_PRIMARY = 2'd1,
    REG_SECOND = 2'd2,
    REG_MODE = 2'd3
  } reg_sel_e;

  localparam logic [2:0] ROM_1MB = 3'd5;
  localparam logic [2:0] ROM_2MB = 3'd6;
  localparam logic [1:0] RAM_QUARTER = 2'd0;
  localparam logic [1:0] RAM_ONE = 2'd1;
  localparam logic [1:0] RAM_FOUR = 2'd2;

  function automatic logic [LOW_W-1:0] size_mask(input logic [2:0] sel);
    logic [LOW_W-1:0] m;
    m = '0;
    for (int i = 0; i < LOW_W; i++)
      if (i <= int'(sel)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bmap_regs.sv
module bmap_regs
  import bmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rom_size_sel,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_wdata,
  input  logic             cpu_we,
  output logic             ram_unlock,
  output logic [LOW_W-1:0] primary,
  output logic [SEC_W-1:0] second,
  output logic             mode
);
  logic     ctl_wr;
  reg_sel_e which;

  assign ctl_wr = cpu_we && !cpu_addr[15];
  assign which  = reg_sel_e'(cpu_addr[14:13]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_unlock <= 1'b0;
      primary    <= LOW_W'(1);
      second     <= '0;
      mode       <= 1'b0;
    end else if (ctl_wr) begin
      case (which)
        REG_UNLOCK:  ram_unlock <= (cpu_wdata[3:0] == 4'hA);
        REG_PRIMARY: primary <= (cpu_wdata[LOW_W-1:0] == '0) ? LOW_W'(1)
                                : (cpu_wdata[LOW_W-1:0] & size_mask(rom_size_sel));
        REG_SECOND:  second <= cpu_wdata[SEC_W-1:0];
        REG_MODE:    mode <= cpu_wdata[0];
        default:     ;
      endcase
    end
  end

  // R2
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'b000) |=> (ram_unlock == ($past(cpu_wdata[3:0]) == 4'hA)));
  // R3
  p_zero_bank_is_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'b001 && cpu_wdata[4:0] == 5'd0) |=> (primary == LOW_W'(1)));
  // R4
  p_mode_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'b011) |=> (mode == $past(cpu_wdata[0])));
  // R4
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> ($stable(primary) && $stable(second) && $stable(mode) && $stable(ram_unlock)));
endmodule

// File: rtl/bmap_rom_xlate.sv
module bmap_rom_xlate
  import bmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rom_size_sel,
  input  logic [15:0]       cpu_addr,
  input  logic [LOW_W-1:0]  primary,
  input  logic [SEC_W-1:0]  second,
  input  logic              mode,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [BANK_W-1:0] hi_bank, lo_bank;

  always_comb begin
    hi_bank = {{SEC_W{1'b0}}, primary};
    lo_bank = '0;
    if (rom_size_sel == ROM_2MB) begin
      hi_bank[BANK_W-1:LOW_W] = second;
      lo_bank[BANK_W-1:LOW_W] = second;
    end else if (rom_size_sel == ROM_1MB) begin
      hi_bank[LOW_W] = second[0];
      lo_bank[LOW_W] = second[0];
    end
    if (!mode) lo_bank = '0;
  end

  assign rom_addr = {(cpu_addr[WIN_W] ? hi_bank : lo_bank), cpu_addr[WIN_W-1:0]};

  // R6
  p_fixed_window_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:WIN_W] == '0));
  // R5
  p_small_rom_no_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_size_sel < ROM_1MB) |-> (rom_addr[ROM_AW-1:WIN_W+LOW_W] == '0));
endmodule

// File: rtl/bmap_ram.sv
module bmap_ram
  import bmap_pkg::*;
#(
  parameter int RAM_AW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ram_size_sel,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_wdata,
  input  logic             cpu_we,
  input  logic             ram_unlock,
  input  logic [SEC_W-1:0] second,
  input  logic             mode,
  output logic [7:0]       ram_rdata
);
  localparam int IDX_W = SEC_W + RAM_AW;
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic             hit;

  assign hit = (cpu_addr[15:13] == 3'b101);

  always_comb begin
    case (ram_size_sel)
      RAM_FOUR: idx = {(mode ? second : {SEC_W{1'b0}}), cpu_addr[RAM_AW-1:0]};
      RAM_ONE:  idx = {{SEC_W{1'b0}}, cpu_addr[RAM_AW-1:0]};
      default:  idx = IDX_W'(cpu_addr[RAM_AW-3:0]);
    endcase
  end

  always_ff @(posedge clk)
    if (cpu_we && hit && ram_unlock) mem[idx] <= cpu_wdata;

  assign ram_rdata = (hit && ram_unlock) ? mem[idx] : 8'hFF;

  // R9
  p_locked_reads_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_unlock |-> (ram_rdata == 8'hFF));
  // R7
  p_mode0_bank0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && hit) |-> (idx[IDX_W-1:RAM_AW] == '0));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bmap_pkg::*;
#(
  parameter int RAM_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rom_size_sel,
  input  logic [1:0]        ram_size_sel,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [7:0]        ram_rdata
);
  logic             ram_unlock, mode;
  logic [LOW_W-1:0] primary;
  logic [SEC_W-1:0] second;

  bmap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rom_size_sel(rom_size_sel),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .ram_unlock(ram_unlock), .primary(primary), .second(second), .mode(mode)
  );

  bmap_rom_xlate u_rom (
    .clk(clk), .rst_n(rst_n), .rom_size_sel(rom_size_sel), .cpu_addr(cpu_addr),
    .primary(primary), .second(second), .mode(mode), .rom_addr(rom_addr)
  );

  bmap_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .ram_size_sel(ram_size_sel), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .ram_unlock(ram_unlock),
    .second(second), .mode(mode), .ram_rdata(ram_rdata)
  );
endmodule

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rom_size_sel = 3'd6;
  logic [1:0]  ram_size_sel = 2'd2;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [20:0] rom_addr;
  logic [7:0]  ram_rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rst_n(rst_n), .rom_size_sel(rom_size_sel), .ram_size_sel(ram_size_sel),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .rom_addr(rom_addr), .ram_rdata(ram_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rom_at(input string req, input logic [15:0] a, input logic [6:0] bank);
    cpu_addr = a; #1;
    chk(req, 32'(rom_addr), 32'({bank, a[13:0]}));
  endtask

  task automatic ram_at(input string req, input logic [15:0] a, input logic [7:0] exp);
    cpu_addr = a; #1;
    chk(req, 32'(ram_rdata), 32'(exp));
  endtask

  task automatic t_reset;
    rom_at("R1", 16'h4000, 7'd1);
    rom_at("R1", 16'h0123, 7'd0);
    ram_at("R1", 16'hA000, 8'hFF);
  endtask

  task automatic t_unlock;
    wr(16'h0000, 8'h1A);
    wr(16'hA000, 8'h55);
    ram_at("R2", 16'hA000, 8'h55);
    wr(16'h1F00, 8'h0B);
    ram_at("R2", 16'hA000, 8'hFF);
    wr(16'hA000, 8'h77);
    wr(16'h0000, 8'hFA);
    ram_at("R9", 16'hA000, 8'h55);
  endtask

  task automatic t_primary;
    rom_size_sel = 3'd6;
    wr(16'h2000, 8'h00); rom_at("R3", 16'h4000, 7'd1);
    wr(16'h3000, 8'hE0); rom_at("R3", 16'h4000, 7'd1);
    wr(16'h2000, 8'h13); rom_at("R3", 16'h4ABC, 7'h13);
    rom_size_sel = 3'd1;
    wr(16'h2000, 8'h06); rom_at("R3", 16'h5000, 7'd2);
    wr(16'h2000, 8'h04); rom_at("R3", 16'h4000, 7'd0);
  endtask

  task automatic t_upper;
    rom_size_sel = 3'd6;
    wr(16'h2000, 8'h13);
    wr(16'h4000, 8'hFF);
    rom_at("R5", 16'h7FFF, 7'h73);
    rom_size_sel = 3'd5; rom_at("R5", 16'h6000, 7'h33);
    rom_size_sel = 3'd4; rom_at("R5", 16'h6000, 7'h13);
    rom_size_sel = 3'd6; rom_at("R6", 16'h0010, 7'd0);
    wr(16'h6000, 8'hFF);
    rom_at("R4", 16'h0010, 7'h60);
    rom_size_sel = 3'd5; rom_at("R6", 16'h3FFF, 7'h20);
    rom_size_sel = 3'd4; rom_at("R6", 16'h0010, 7'd0);
    wr(16'h6000, 8'hFE);
    rom_size_sel = 3'd6; rom_at("R4", 16'h0010, 7'd0);
  endtask

  task automatic t_ram_banks;
    ram_size_sel = 2'd2;
    wr(16'h0000, 8'h0A);
    wr(16'h6000, 8'h00);
    wr(16'h4000, 8'h00);
    wr(16'hA005, 8'h99);
    wr(16'h6000, 8'h01);
    wr(16'h4000, 8'h02); wr(16'hA005, 8'h22);
    wr(16'h4000, 8'h01); wr(16'hA005, 8'h11);
    wr(16'h4000, 8'h02); ram_at("R7", 16'hA005, 8'h22);
    wr(16'h4000, 8'h01); ram_at("R7", 16'hA005, 8'h11);
    wr(16'h4000, 8'h00); ram_at("R7", 16'hA005, 8'h99);
    wr(16'h4000, 8'h01); wr(16'h6000, 8'h00);
    ram_at("R7", 16'hA005, 8'h99);
  endtask

  task automatic t_ram_wrap;
    ram_size_sel = 2'd0;
    wr(16'hA003, 8'h3C);
    ram_at("R8", 16'hA083, 8'h3C);
    ram_size_sel = 2'd1;
    wr(16'hA010, 8'h5A);
    ram_at("R8", 16'hA210, 8'h5A);
    wr(16'h6000, 8'h01); wr(16'h4000, 8'h03);
    ram_at("R8", 16'hA010, 8'h5A);
    ram_at("R9", 16'h8000, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_unlock;
    t_primary;
    t_upper;
    t_ram_banks;
    t_ram_wrap;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule